// File: doc/BRIEF.md
# Two-Word Masked Interrupt Cause Unit

The unit gathers up to 64 interrupt source levels into a 64-bit cause vector and combines it with a 64-bit CPU mask. From the two it drives one CPU interrupt line. The cause vector follows the source levels. Software cannot write it, and a set of reserved positions is tied to zero.

Software reaches the unit through a small 32-bit register port. It can read both cause words, and it can write and read both mask words. A fifth register, the select word, returns whichever cause half holds pending masked sources. Flag bits in that word tell software which case applies, so one read is enough to decide which half to service. Sources 56 to 59 carry the four GPIO group interrupts (pins 0–7, 8–15, 16–23 and 24–31), and source 60 carries a CPU doorbell. All of them appear in the high cause word at bits 24 to 28.

Top module: `irq_cause_unit`

## Requirements
- R1: After a synchronous active-low reset, every readable register reads 0 and `cpu_irq` is 0.
- R2: On each clock edge, cause bit i takes the level of `src_lvl[i]`. Register address 0 returns cause bits 31:0 and address 1 returns cause bits 63:32.
- R3: Cause positions 29, 30, 31, 35, 51–55 and 61–63 always read 0, whatever their source levels are.
- R4: Address 2 writes and reads mask bits 31:0, and address 3 writes and reads mask bits 63:32. A write to one half leaves the other half unchanged.
- R5: Writes to addresses 0, 1 and 4 have no effect on the cause vector.
- R6: `cpu_irq` is the OR of all bits of (cause AND mask), registered. It therefore responds on the second clock edge after a source level change.
- R7: A select read (address 4) with no masked source pending returns cause bits 31:0 unchanged.
- R8: A select read with masked sources pending only in bits 63:32 returns cause bits 63:32 with bit 30 set.
- R9: A select read with masked sources pending in both halves returns cause bits 31:0 with bit 31 set.
- R10: A select read with masked sources pending only in bits 31:0 returns cause bits 31:0 with bit 31 clear.
- R11: `rd_data` is loaded on the edge where `rd_en` is high and holds otherwise. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | 64 | Interrupt source levels, one per cause position |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select (0 cause low, 1 cause high, 2 mask low, 3 mask high, 4 select) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid from the edge after `rd_en` |
| cpu_irq | output | 1 | CPU interrupt line |

## Verification
The bench builds the unit with its default parameters: 32-bit words and the default reserved-position pattern. With that pattern the select-word flags at bits 30 and 31 fall on reserved cause positions, so a set flag cannot be mistaken for a real source. This lets the bench drive every source bit high and check that the reserved bits stay clear. Directed patterns cover each of the four select-word outcomes. Two further tests confirm the exact two-edge latency from a source change to `cpu_irq`, and that one mask half is not disturbed when the other is written.

// File: rtl/icu_pkg.sv
`timescale 1ns/1ps
// Package: shared register codes and select-word flag positions for the
// interrupt cause unit. Assumes a 3-bit register address.
package icu_pkg;
    localparam int ICU_ADDR_W   = 3;
    localparam int SEL_HI_FLAG  = 30;   // high half alone pending
    localparam int SEL_BOTH_FLAG = 31;  // both halves pending

    typedef enum logic [ICU_ADDR_W-1:0] {
        ICU_CAUSE_LO = 3'd0,
        ICU_CAUSE_HI = 3'd1,
        ICU_MASK_LO  = 3'd2,
        ICU_MASK_HI  = 3'd3,
        ICU_SELECT   = 3'd4
    } icu_reg_e;
endpackage

// File: rtl/icu_cause_capture.sv
`timescale 1ns/1ps
// Module: icu_cause_capture
// Registers the source levels into the cause vector once per clock.
// Positions flagged in RSVD_MASK are tied to zero and carry no flop.
// Assumes the source levels are already synchronous to clk.
module icu_cause_capture #(
    parameter int          WORD_W    = 32,
    parameter logic [63:0] RSVD_MASK = 64'hE0F80008_E0000000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*WORD_W-1:0] src_lvl,
    output logic [2*WORD_W-1:0] cause_q
);
    localparam int SRC_W = 2 * WORD_W;

    for (genvar i = 0; i < SRC_W; i++) begin : g_bit
        if (RSVD_MASK[i]) begin : g_tied
            assign cause_q[i] = 1'b0;
        end else begin : g_live
            logic bit_q;
            // Capture one source level per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= src_lvl[i];
            end
            assign cause_q[i] = bit_q;
        end
    end
endmodule

// File: rtl/icu_mask_regs.sv
`timescale 1ns/1ps
// Module: icu_mask_regs
// Holds the CPU mask as two independently written halves.
// Assumes at most one half-select is high per write.
module icu_mask_regs #(
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          half_sel,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [2*WORD_W-1:0] mask_q
);
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [WORD_W-1:0] half_q;
        // Load this half only when it is the addressed one.
        always_ff @(posedge clk) begin
            if (!rst_n)                   half_q <= '0;
            else if (wr_en && half_sel[h]) half_q <= wr_data;
        end
        assign mask_q[h*WORD_W +: WORD_W] = half_q;
    end
endmodule

// File: rtl/icu_read_mux.sv
`timescale 1ns/1ps
// Module: icu_read_mux
// Combinational read decode, including the select-word rule.
// The select-word flags sit at bits 30 and 31, so WORD_W must be at least 32.
module icu_read_mux
    import icu_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [ICU_ADDR_W-1:0] reg_addr,
    input  logic [2*WORD_W-1:0]   cause_q,
    input  logic [2*WORD_W-1:0]   mask_q,
    output logic [WORD_W-1:0]     rd_word
);
    logic [2*WORD_W-1:0] pend;
    logic                lo_pend;
    logic                hi_pend;
    logic [WORD_W-1:0]   sel_word;

    assign pend    = cause_q & mask_q;
    assign lo_pend = |pend[WORD_W-1:0];
    assign hi_pend = |pend[2*WORD_W-1:WORD_W];

    // Select word: choose the half that holds pending masked sources.
    always_comb begin
        sel_word = cause_q[WORD_W-1:0];
        if (hi_pend && !lo_pend) begin
            sel_word = cause_q[2*WORD_W-1:WORD_W];
            sel_word[SEL_HI_FLAG] = 1'b1;
        end else if (hi_pend && lo_pend) begin
            sel_word[SEL_BOTH_FLAG] = 1'b1;
        end
    end

    // Address decode for reads; unused codes return zero.
    always_comb begin
        case (icu_reg_e'(reg_addr))
            ICU_CAUSE_LO: rd_word = cause_q[WORD_W-1:0];
            ICU_CAUSE_HI: rd_word = cause_q[2*WORD_W-1:WORD_W];
            ICU_MASK_LO:  rd_word = mask_q[WORD_W-1:0];
            ICU_MASK_HI:  rd_word = mask_q[2*WORD_W-1:WORD_W];
            ICU_SELECT:   rd_word = sel_word;
            default:      rd_word = '0;
        endcase
    end
endmodule

// File: rtl/irq_cause_unit.sv
`timescale 1ns/1ps
// Module: irq_cause_unit (top)
// 64-source cause vector, split CPU mask, registered interrupt line and
// registered read data. Cause is read-only from the register port.
// Assumes single-cycle read/write strobes with a stable address.
module irq_cause_unit
    import icu_pkg::*;
#(
    parameter int          WORD_W    = 32,
    parameter logic [63:0] RSVD_MASK = 64'hE0F80008_E0000000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*WORD_W-1:0]   src_lvl,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ICU_ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0]     wr_data,
    output logic [WORD_W-1:0]     rd_data,
    output logic                  cpu_irq
);
    logic [2*WORD_W-1:0] cause_q;
    logic [2*WORD_W-1:0] mask_q;
    logic [1:0]          mask_sel;
    logic [WORD_W-1:0]   rd_word;

    assign mask_sel[0] = (icu_reg_e'(reg_addr) == ICU_MASK_LO);
    assign mask_sel[1] = (icu_reg_e'(reg_addr) == ICU_MASK_HI);

    icu_cause_capture #(.WORD_W(WORD_W), .RSVD_MASK(RSVD_MASK)) u_cause (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .cause_q(cause_q)
    );

    icu_mask_regs #(.WORD_W(WORD_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .half_sel(mask_sel),
        .wr_data(wr_data), .mask_q(mask_q)
    );

    icu_read_mux #(.WORD_W(WORD_W)) u_rmux (
        .reg_addr(reg_addr), .cause_q(cause_q), .mask_q(mask_q),
        .rd_word(rd_word)
    );

    // Register the OR of all masked pending causes onto the CPU line.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_irq <= 1'b0;
        else        cpu_irq <= |(cause_q & mask_q);
    end

    // Latch read data on a read strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_word;
    end
endmodule

// File: rtl/icu_chk.sv
`timescale 1ns/1ps
// Module: icu_chk
// Assertion checker bound to irq_cause_unit. Observes ports and the
// cause and mask vectors driven by separate submodules.
module icu_chk
    import icu_pkg::*;
#(
    parameter int          WORD_W    = 32,
    parameter logic [63:0] RSVD_MASK = 64'hE0F80008_E0000000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [2*WORD_W-1:0]   src_lvl,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [ICU_ADDR_W-1:0] reg_addr,
    input logic [WORD_W-1:0]     rd_data,
    input logic                  cpu_irq,
    input logic [2*WORD_W-1:0]   cause_q,
    input logic [2*WORD_W-1:0]   mask_q
);
    localparam logic [2*WORD_W-1:0] LIVE = ~RSVD_MASK[2*WORD_W-1:0];
    localparam logic [WORD_W-1:0]   RSVD_LO = RSVD_MASK[WORD_W-1:0];

    logic [1:0] live_cyc;
    // Count clock edges since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)             live_cyc <= 2'd0;
        else if (live_cyc != 3) live_cyc <= live_cyc + 2'd1;
    end

    AST_RSVD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr == ICU_CAUSE_LO) |=> ((rd_data & RSVD_LO) == '0)); // R3

    AST_MASK_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == ICU_MASK_LO) |=> $stable(mask_q[2*WORD_W-1:WORD_W])); // R4

    AST_IRQ_TRACKS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cyc >= 2'd2) |-> (cpu_irq == |($past(src_lvl, 2) & LIVE & $past(mask_q, 1)))); // R6

    AST_SEL_HI_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr == ICU_SELECT && ((cause_q & mask_q) != '0)
         && ((cause_q[WORD_W-1:0] & mask_q[WORD_W-1:0]) == '0))
        |=> rd_data[SEL_HI_FLAG]); // R8

    AST_SEL_BOTH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr == ICU_SELECT
         && ((cause_q[WORD_W-1:0] & mask_q[WORD_W-1:0]) != '0)
         && ((cause_q[2*WORD_W-1:WORD_W] & mask_q[2*WORD_W-1:WORD_W]) != '0))
        |=> rd_data[SEL_BOTH_FLAG]); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R11
endmodule

bind irq_cause_unit icu_chk #(.WORD_W(WORD_W), .RSVD_MASK(RSVD_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .wr_en(wr_en),
    .rd_en(rd_en), .reg_addr(reg_addr), .rd_data(rd_data),
    .cpu_irq(cpu_irq), .cause_q(cause_q), .mask_q(mask_q)
);

// File: tb/sim_irq_cause_unit.sv
`timescale 1ns/1ps
// Directed bench for irq_cause_unit: one task per scenario.
module sim_irq_cause_unit;
    localparam logic [63:0] RSVD = 64'hE0F80008_E0000000; // R3 positions

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_lvl = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        cpu_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_cause_unit u0 (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .wr_en(wr_en),
        .rd_en(rd_en), .reg_addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .cpu_irq(cpu_irq)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    // Apply sources and let two edges pass (cause, then irq).
    task automatic set_src(input logic [63:0] v);
        @(negedge clk);
        src_lvl = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", {63'd0, cpu_irq}, 64'd0);
        for (int a = 0; a < 5; a++) begin
            reg_rd(3'(a), d);
            check("R1 reg", {32'd0, d}, 64'd0);
        end
    endtask

    task automatic t_cause();
        logic [31:0] lo, hi;
        logic [63:0] pat;
        pat = 64'h1F00_0123_0ABC_DEF5; // bits 56..60 set: GPIO groups and doorbell
        set_src(pat);
        reg_rd(3'd0, lo); reg_rd(3'd1, hi);
        check("R2 lo", {32'd0, lo}, {32'd0, pat[31:0] & ~RSVD[31:0]});
        check("R2 hi", {32'd0, hi}, {32'd0, pat[63:32] & ~RSVD[63:32]});
        set_src('1);
        reg_rd(3'd0, lo); reg_rd(3'd1, hi);
        check("R3 lo", {32'd0, lo}, 64'h0000_0000_1FFF_FFFF);
        check("R3 hi", {32'd0, hi}, 64'h0000_0000_1F07_FFF7);
        set_src('0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        reg_wr(3'd2, 32'hA5A5_0F0F);
        reg_rd(3'd2, d); check("R4 lo", {32'd0, d}, 64'hA5A5_0F0F);
        reg_rd(3'd3, d); check("R4 hi untouched", {32'd0, d}, 64'd0);
        reg_wr(3'd3, 32'h1234_5678);
        reg_rd(3'd2, d); check("R4 lo kept", {32'd0, d}, 64'hA5A5_0F0F);
        reg_rd(3'd3, d); check("R4 hi", {32'd0, d}, 64'h1234_5678);
        reg_wr(3'd2, 32'd0); reg_wr(3'd3, 32'd0);
    endtask

    task automatic t_cause_ro();
        logic [31:0] d;
        set_src('0);
        reg_wr(3'd0, 32'hFFFF_FFFF);
        reg_wr(3'd1, 32'hFFFF_FFFF);
        reg_wr(3'd4, 32'hFFFF_FFFF);
        reg_rd(3'd0, d); check("R5 lo", {32'd0, d}, 64'd0);
        reg_rd(3'd1, d); check("R5 hi", {32'd0, d}, 64'd0);
    endtask

    task automatic t_irq();
        set_src(64'h0000_0000_0000_0008);
        check("R6 unmasked", {63'd0, cpu_irq}, 64'd0);
        reg_wr(3'd2, 32'h0000_0008);
        @(negedge clk);
        check("R6 masked low", {63'd0, cpu_irq}, 64'd1);
        @(negedge clk);
        src_lvl = '0;
        @(negedge clk); // one edge: cause cleared, irq not yet
        check("R6 latency", {63'd0, cpu_irq}, 64'd1);
        @(negedge clk);
        check("R6 drop", {63'd0, cpu_irq}, 64'd0);
        reg_wr(3'd2, 32'd0);
        reg_wr(3'd3, 32'h1000_0000);
        set_src(64'h1000_0000_0000_0000); // doorbell source 60
        check("R6 masked high", {63'd0, cpu_irq}, 64'd1);
        reg_wr(3'd3, 32'd0);
        set_src('0);
    endtask

    task automatic t_select();
        logic [31:0] d;
        logic [63:0] pat;
        pat = 64'h0100_0040_0000_0004; // sources 2, 38, 56
        set_src(pat);
        reg_rd(3'd4, d); check("R7 none", {32'd0, d}, 64'h0000_0000_0000_0004);
        reg_wr(3'd3, 32'h0100_0000);
        reg_rd(3'd4, d); check("R8 high only", {32'd0, d}, 64'h0000_0000_4100_0040);
        reg_wr(3'd2, 32'h0000_0004);
        reg_rd(3'd4, d); check("R9 both", {32'd0, d}, 64'h0000_0000_8000_0004);
        reg_wr(3'd3, 32'd0);
        reg_rd(3'd4, d); check("R10 low only", {32'd0, d}, 64'h0000_0000_0000_0004);
        reg_wr(3'd2, 32'd0);
        set_src('0);
    endtask

    task automatic t_rdhold();
        logic [31:0] d;
        reg_wr(3'd2, 32'hCAFE_0001);
        reg_rd(3'd5, d); check("R11 unused addr", {32'd0, d}, 64'd0);
        reg_rd(3'd2, d); check("R11 read", {32'd0, d}, 64'hCAFE_0001);
        reg_wr(3'd2, 32'h0000_0000);
        @(negedge clk); @(negedge clk);
        check("R11 hold", {32'd0, rd_data}, 64'hCAFE_0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cause();
        t_mask();
        t_cause_ro();
        t_irq();
        t_select();
        t_rdhold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule